// File: doc/BRIEF.md
# LIN Bus Wakeup Detector with Latched Indication

This block watches the digitised output of a LIN bus receiver comparator and decides when a remote node has asked for a wakeup. A request counts only when the bus has been held dominant for a minimum number of sample ticks and has then gone back to recessive. The dominant phase may begin while the transceiver is still in active mode, provided it ends in wakeup mode. Each accepted request produces a one-cycle event for the mode controller. It also sets a flag that pulls the receive pin low, so that the host sees a pending wakeup.

The receive pin level depends on the transceiver mode. In active mode it follows the bus comparator directly. In wakeup mode it shows the inverse of the wakeup flag. In off mode it is held high, and the timer and the flag are kept clear. The host clears the flag by driving enable high, and the mode controller can clear it with a strobe. The tick input sets the sampling rate, so the minimum dominant time is the tick period multiplied by `WAKE_TICKS`.

Top module: `lwk_wakeup_detect`

## Requirements
- R1: In wakeup mode (`xcvr_mode` = 2'b01), a recessive sample (`tick`=1, `bus_rx`=1) taken after at least `WAKE_TICKS` consecutive dominant samples sets the wakeup flag and raises `wake_evt` in the cycle after that clock edge.
- R2: A dominant phase of fewer than `WAKE_TICKS` dominant samples, followed by a recessive sample, produces no `wake_evt` and leaves `rxd` high.
- R3: Dominant samples taken in active mode (`xcvr_mode` = 2'b10) count toward the duration. The pulse is accepted only if its terminating recessive sample is taken in wakeup mode. A pulse that ends while still in active mode leaves the count at zero.
- R4: In off mode (`xcvr_mode` = 2'b00, and 2'b11 is treated the same way), `rxd` is 1, no detection occurs, the dominant count is cleared and the flag is cleared.
- R5: In active mode `rxd` equals `bus_rx` within the same cycle.
- R6: In wakeup mode `rxd` is low while the flag is set. The flag is cleared at the first clock edge with `en`=1 or `flag_clr`=1. A clear at the same edge as a detection wins, so `rxd` stays high although `wake_evt` still pulses.
- R7: `wake_evt` is high for exactly one clock cycle per accepted wakeup.
- R8: The dominant count changes only on cycles with `tick`=1, resets on any recessive tick sample, and saturates at `WAKE_TICKS`. A recessive level on a cycle without a tick has no effect.
- R9: After reset, `wake_evt` is 0 and, in wakeup mode, `rxd` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Sample strobe for the bus level |
| bus_rx | input | 1 | Receiver comparator output, 1 = recessive, 0 = dominant |
| xcvr_mode | input | 2 | Transceiver mode: 00 off, 01 wakeup, 10 active, 11 treated as off |
| en | input | 1 | Host enable level, clears the flag while high |
| flag_clr | input | 1 | Clear strobe from the mode controller |
| rxd | output | 1 | Receive pin level |
| wake_evt | output | 1 | One-cycle wakeup event to the mode controller |

## Verification
Dominant pulse lengths are swept from one sample up to several samples past the threshold, first with a tick on every cycle and then with a tick every third cycle. This separates the off-by-one boundary at `WAKE_TICKS`, saturation on long pulses, and tick gating. Pulses that cross from active to wakeup mode are set against pulses that end inside active mode, to separate counting from acceptance. Recessive glitches placed on and off tick cycles show whether the count resets only on sampled recessive levels. Clears by enable, clears by strobe, clears that coincide with a detection, and dwelling in off mode separate the flag's priority rules from the receive-pin selection.

// File: rtl/lwk_pkg.sv
// Shared types for the LIN wakeup detector.
// Assumes a two-bit mode code supplied by the transceiver mode controller.
package lwk_pkg;
    typedef enum logic [1:0] {
        LWK_OFF    = 2'b00,
        LWK_WAKE   = 2'b01,
        LWK_ACTIVE = 2'b10,
        LWK_RSVD   = 2'b11
    } lwk_mode_e;

    // True for modes where dominant samples are timed.
    function automatic logic lwk_listening(lwk_mode_e m);
        return (m == LWK_WAKE) || (m == LWK_ACTIVE);
    endfunction
endpackage

// File: rtl/lwk_dom_timer.sv
// Dominant-duration timer.
// Counts consecutive dominant samples taken on tick cycles and saturates at
// WAKE_TICKS. Any recessive tick sample, or a non-listening mode, clears it.
// Assumes bus_rx is already synchronised to clk.
module lwk_dom_timer #(
    parameter int WAKE_TICKS = 80,
    parameter int CNT_W      = $clog2(WAKE_TICKS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             bus_rx,
    input  logic             listen,
    output logic [CNT_W-1:0] dom_cnt,
    output logic             qualified
);
    localparam logic [CNT_W-1:0] CAP = CNT_W'(WAKE_TICKS);

    // Advance, hold or clear the dominant count.
    always_ff @(posedge clk) begin
        if (!rst_n || !listen) begin
            dom_cnt <= '0;
        end else if (tick) begin
            if (bus_rx)
                dom_cnt <= '0;
            else if (dom_cnt < CAP)
                dom_cnt <= dom_cnt + 1'b1;
        end
    end

    // The pulse has been long enough once the count reaches the cap.
    always_comb qualified = (dom_cnt == CAP);
endmodule

// File: rtl/lwk_flag.sv
// Wakeup acceptance and flag.
// A recessive tick sample in wakeup mode, after a qualified dominant phase,
// raises a one-cycle event and sets the flag. Enable, the clear strobe or a
// non-listening mode clear the flag, and a clear wins over a set.
module lwk_flag
    import lwk_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick,
    input  logic      bus_rx,
    input  lwk_mode_e mode,
    input  logic      qualified,
    input  logic      en,
    input  logic      flag_clr,
    output logic      wk_flag,
    output logic      wake_evt
);
    logic detect;
    logic clear;

    // Acceptance condition: end of a long enough dominant phase in wakeup mode.
    always_comb detect = tick && bus_rx && qualified && (mode == LWK_WAKE);

    // Sources that drop the flag.
    always_comb clear = en || flag_clr || !lwk_listening(mode);

    // Flag register with clear priority.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            wk_flag <= 1'b0;
        else if (detect)
            wk_flag <= 1'b1;
    end

    // Registered single-cycle event for the mode controller.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wake_evt <= 1'b0;
        else
            wake_evt <= detect;
    end
endmodule

// File: rtl/lwk_rxd_mux.sv
// Receive pin selector.
// Active mode passes the comparator through, wakeup mode shows the inverse of
// the flag, and off or reserved modes hold the pin high.
module lwk_rxd_mux
    import lwk_pkg::*;
(
    input  lwk_mode_e mode,
    input  logic      bus_rx,
    input  logic      wk_flag,
    output logic      rxd
);
    // Select the pin level by mode.
    always_comb begin
        case (mode)
            LWK_ACTIVE: rxd = bus_rx;
            LWK_WAKE:   rxd = !wk_flag;
            default:    rxd = 1'b1;
        endcase
    end
endmodule

// File: rtl/lwk_wakeup_detect.sv
// LIN bus wakeup detector, top level.
// Times dominant phases, accepts wakeups and drives the receive pin.
// Assumes all inputs are synchronous to clk and tick is a one-cycle strobe.
module lwk_wakeup_detect
    import lwk_pkg::*;
#(
    parameter int WAKE_TICKS = 80
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       bus_rx,
    input  logic [1:0] xcvr_mode,
    input  logic       en,
    input  logic       flag_clr,
    output logic       rxd,
    output logic       wake_evt
);
    localparam int CNT_W = $clog2(WAKE_TICKS + 1);

    lwk_mode_e         mode;
    logic [CNT_W-1:0]  dom_cnt;
    logic              qualified;
    logic              wk_flag;

    // Interpret the raw mode code.
    always_comb mode = lwk_mode_e'(xcvr_mode);

    lwk_dom_timer #(
        .WAKE_TICKS(WAKE_TICKS),
        .CNT_W     (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .bus_rx   (bus_rx),
        .listen   (lwk_listening(mode)),
        .dom_cnt  (dom_cnt),
        .qualified(qualified)
    );

    lwk_flag u_flag (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .bus_rx   (bus_rx),
        .mode     (mode),
        .qualified(qualified),
        .en       (en),
        .flag_clr (flag_clr),
        .wk_flag  (wk_flag),
        .wake_evt (wake_evt)
    );

    lwk_rxd_mux u_mux (
        .mode   (mode),
        .bus_rx (bus_rx),
        .wk_flag(wk_flag),
        .rxd    (rxd)
    );
endmodule

// File: rtl/lwk_checker.sv
// Property checker for lwk_wakeup_detect, attached with bind.
module lwk_checker #(
    parameter int WAKE_TICKS = 80,
    parameter int CNT_W      = $clog2(WAKE_TICKS + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             bus_rx,
    input logic [1:0]       xcvr_mode,
    input logic             en,
    input logic             rxd,
    input logic             wake_evt,
    input logic [CNT_W-1:0] dom_cnt,
    input logic             wk_flag
);
    AST_CNT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        dom_cnt <= CNT_W'(WAKE_TICKS)); // R8
    AST_CNT_CLR_RECESSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && bus_rx) |=> (dom_cnt == '0)); // R8
    AST_OFF_RXD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (xcvr_mode == 2'b00) |-> rxd); // R4
    AST_EVT_IN_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        wake_evt |-> ($past(xcvr_mode) == 2'b01)); // R1
    AST_EVT_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        wake_evt |-> ($past(dom_cnt) == CNT_W'(WAKE_TICKS))); // R2
    AST_EVT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wake_evt |=> !wake_evt); // R7
    AST_EN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> !wk_flag); // R6
endmodule

bind lwk_wakeup_detect lwk_checker #(
    .WAKE_TICKS(WAKE_TICKS),
    .CNT_W     (CNT_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .bus_rx   (bus_rx),
    .xcvr_mode(xcvr_mode),
    .en       (en),
    .rxd      (rxd),
    .wake_evt (wake_evt),
    .dom_cnt  (dom_cnt),
    .wk_flag  (wk_flag)
);

// File: tb/tb_lwk_wakeup_detect.sv
module tb_lwk_wakeup_detect;
    localparam int W = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b1;
    logic       bus_rx = 1'b1;
    logic [1:0] xcvr_mode = 2'b01;
    logic       en = 1'b0;
    logic       flag_clr = 1'b0;
    logic       rxd;
    logic       wake_evt;

    int n_run = 0;
    int n_fail = 0;
    int evt_cnt = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    lwk_wakeup_detect #(.WAKE_TICKS(W)) dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .bus_rx(bus_rx),
        .xcvr_mode(xcvr_mode), .en(en), .flag_clr(flag_clr),
        .rxd(rxd), .wake_evt(wake_evt)
    );

    task automatic chk(string req, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One clock with given bus level and tick; counts events seen after the edge.
    task automatic cyc(logic b, logic t);
        bus_rx = b;
        tick = t;
        @(posedge clk);
        @(negedge clk);
        if (wake_evt) evt_cnt++;
    endtask

    task automatic clear_flag(bit use_en);
        if (use_en) en = 1'b1; else flag_clr = 1'b1;
        cyc(1'b1, 1'b1);
        en = 1'b0;
        flag_clr = 1'b0;
    endtask

    // n dominant ticks, one tick every div cycles, then a recessive tick phase.
    task automatic pulse(int n, int div);
        evt_cnt = 0;
        for (int k = 0; k < n * div; k++) cyc(1'b0, (k % div) == 0);
        for (int k = 0; k < div; k++) cyc(1'b1, (k % div) == 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 rxd after reset", rxd, 1);
        chk("R9 wake_evt after reset", wake_evt, 0);

        // Sweep of pulse lengths and tick spacing (R1 R2 R7 R8).
        for (int div = 1; div <= 3; div += 2) begin
            for (int n = 1; n <= W + 3; n++) begin
                pulse(n, div);
                chk(n >= W ? "R1 event count" : "R2 short pulse event count",
                    evt_cnt, (n >= W) ? 1 : 0);
                chk(n > W ? "R8 saturated rxd" : "R1_R2 rxd after pulse",
                    rxd, (n >= W) ? 0 : 1);
                clear_flag(n[0]);
                chk("R6 rxd after clear", rxd, 1);
            end
        end

        // Active mode passthrough (R5).
        xcvr_mode = 2'b10;
        bus_rx = 1'b0; #1 chk("R5 rxd follows dominant", rxd, 0);
        bus_rx = 1'b1; #1 chk("R5 rxd follows recessive", rxd, 1);
        @(negedge clk);

        // Pulse begun in active, ended in wakeup mode (R3).
        evt_cnt = 0;
        for (int k = 0; k < W - 1; k++) cyc(1'b0, 1'b1);
        xcvr_mode = 2'b01;
        cyc(1'b0, 1'b1);
        cyc(1'b1, 1'b1);
        chk("R3 cross-mode pulse accepted", evt_cnt, 1);
        chk("R3 cross-mode rxd", rxd, 0);
        clear_flag(1'b1);

        // Pulse ended inside active mode is not carried over (R3).
        xcvr_mode = 2'b10;
        evt_cnt = 0;
        for (int k = 0; k < W + 2; k++) cyc(1'b0, 1'b1);
        cyc(1'b1, 1'b1);
        xcvr_mode = 2'b01;
        cyc(1'b1, 1'b1);
        chk("R3 pulse ending in active ignored", evt_cnt, 0);
        chk("R3 rxd after active-only pulse", rxd, 1);

        // Off mode: no detection, rxd high, flag dropped (R4).
        pulse(W, 1);
        chk("R4 setup flag set", rxd, 0);
        xcvr_mode = 2'b00;
        #1 chk("R4 rxd high in off", rxd, 1);
        evt_cnt = 0;
        for (int k = 0; k < 2 * W; k++) cyc(1'b0, 1'b1);
        chk("R4 rxd high on dominant in off", rxd, 1);
        cyc(1'b1, 1'b1);
        chk("R4 no event in off", evt_cnt, 0);
        xcvr_mode = 2'b01;
        cyc(1'b1, 1'b1);
        chk("R4 flag cleared by off", rxd, 1);
        // Count cleared by off mode: short wakeup-mode tail must not qualify.
        xcvr_mode = 2'b00;
        evt_cnt = 0;
        for (int k = 0; k < W; k++) cyc(1'b0, 1'b1);
        xcvr_mode = 2'b01;
        cyc(1'b0, 1'b1);
        cyc(1'b1, 1'b1);
        chk("R4 count cleared in off", evt_cnt, 0);

        // Clear coinciding with detection wins (R6).
        evt_cnt = 0;
        for (int k = 0; k < W; k++) cyc(1'b0, 1'b1);
        en = 1'b1;
        cyc(1'b1, 1'b1);
        en = 1'b0;
        chk("R6 event with coincident enable", evt_cnt, 1);
        chk("R6 enable wins over set", rxd, 1);
        evt_cnt = 0;
        for (int k = 0; k < W; k++) cyc(1'b0, 1'b1);
        flag_clr = 1'b1;
        cyc(1'b1, 1'b1);
        flag_clr = 1'b0;
        chk("R6 strobe wins over set", rxd, 1);
        // Flag holds while neither clear is present (R6).
        pulse(W, 1);
        for (int k = 0; k < 5; k++) cyc(1'b1, 1'b1);
        chk("R6 flag held", rxd, 0);
        clear_flag(1'b0);

        // Recessive off-tick glitch has no effect (R8).
        evt_cnt = 0;
        for (int k = 0; k < W - 1; k++) cyc(1'b0, 1'b1);
        cyc(1'b1, 1'b0);
        cyc(1'b0, 1'b1);
        cyc(1'b1, 1'b1);
        chk("R8 untimed recessive ignored", evt_cnt, 1);
        clear_flag(1'b1);
        // Recessive tick splits the pulse (R8).
        evt_cnt = 0;
        for (int k = 0; k < W - 2; k++) cyc(1'b0, 1'b1);
        cyc(1'b1, 1'b1);
        for (int k = 0; k < W - 2; k++) cyc(1'b0, 1'b1);
        cyc(1'b1, 1'b1);
        chk("R8 recessive tick resets count", evt_cnt, 0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule